// File: doc/BRIEF.md
# Regulator Bypass Command Register

This block holds one 32-bit command word through which host software sends a single raw register write to an external voltage regulator, outside the normal state-driven sequencing. The word carries the byte to write, the regulator register address, the regulator's 7-bit bus address, a launch/busy flag and a sticky error flag. Software first writes the word with the flag clear to load the fields, then writes it again with the flag set to start the transfer. It then polls the same word until hardware clears the flag.

The block hands the transfer to a serial bus engine through a request/done handshake. The same engine also serves a second requester, the power state sequencer. When both requesters are waiting while the engine is free, the software command goes first. The fields of the granted request are captured at grant time and stay frozen until the engine reports completion. A not-acknowledge from the bus ends the software transfer just as a success does, and it also raises the error flag. Software clears that flag by writing a one to it.

Top module: `bypass_cmd_reg`

## Requirements
- R1: After reset the word reads 0x00000000 and `eng_req` is low.
- R2: Word layout: data in bits 7:0, regulator register address in bits 15:8, bus address in bits 22:16, launch/busy flag in bit 24, error flag in bit 31. Bits 23 and 30:25 always read 0. A write with bit 24 clear, made while the flag is clear, loads the three fields, and they read back from the next cycle on. Such a write starts no transfer.
- R3: A write with bit 24 set, made while the flag is clear, loads the fields and sets the flag on the next cycle. If the engine is free, `eng_req` rises one cycle later, with the written fields on `eng_data`, `eng_reg` and `eng_slave`.
- R4: The flag reads 1 for as long as the software transfer is pending. It reads 0 from the cycle after `eng_done` ends that transfer.
- R5: While the flag is set, host writes do not change the data, register address or bus address fields.
- R6: When the engine is free and a software command and a sequencer request are both waiting, the software command is granted first.
- R7: A sequencer request is sent with the fields present on `st_*` at grant. `st_done` is high exactly in the cycle in which `eng_done` ends a sequencer transfer, and in no other cycle.
- R8: If `eng_nack` is high together with `eng_done` at the end of a software transfer, the flag clears as in R4 and bit 31 reads 1 from the next cycle. Bit 31 then stays set until software clears it.
- R9: A host write with bit 31 set clears the error flag. A write with bit 31 clear leaves the error flag unchanged.
- R10: While `eng_req` is high and `eng_done` is low, `eng_req` stays high on the next cycle and the `eng_*` fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Live value of the command word |
| st_req | input | 1 | Sequencer request, held until `st_done` |
| st_slave | input | 7 | Sequencer bus address |
| st_reg | input | 8 | Sequencer register address |
| st_data | input | 8 | Sequencer data byte |
| st_done | output | 1 | Sequencer transfer finished |
| eng_req | output | 1 | Request to the bus engine, held until `eng_done` |
| eng_slave | output | 7 | Bus address of the granted request |
| eng_reg | output | 8 | Register address of the granted request |
| eng_data | output | 8 | Data byte of the granted request |
| eng_done | input | 1 | Engine finished the current transfer (one-cycle pulse) |
| eng_nack | input | 1 | Qualifies `eng_done`: the regulator did not acknowledge |

## Verification
Results appear at fixed cycle offsets:
- A host write changes `host_rdata` one cycle after its clock edge.
- A grant (`eng_req` and the `eng_*` fields) follows one further cycle after the flag becomes set, or one cycle after a finished transfer frees the engine.
- `st_done` is combinational with `eng_done`, so it is sampled inside the pulse.
- The flag and error bits reflect an `eng_done` one cycle after it.

The bench drives inputs on falling edges and samples on falling edges, counting exactly these edges. This places every check in the first cycle in which the new value is due. Where a value must persist, the bench checks it again on later cycles.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int WORD_W    = 32;
  localparam int DATA_W    = 8;
  localparam int REG_W     = 8;
  localparam int SLV_W     = 7;
  localparam int DATA_LSB  = 0;
  localparam int REG_LSB   = DATA_LSB + DATA_W;
  localparam int SLV_LSB   = REG_LSB + REG_W;
  localparam int VALID_BIT = SLV_LSB + SLV_W + 1;
  localparam int ERR_BIT   = WORD_W - 1;

  typedef struct packed {
    logic [SLV_W-1:0]  slv;
    logic [REG_W-1:0]  ra;
    logic [DATA_W-1:0] dat;
  } cmd_t;

  typedef enum logic [1:0] {OWN_IDLE, OWN_BYP, OWN_ST} owner_e;

  function automatic cmd_t cmd_from_word(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.dat = w[DATA_LSB +: DATA_W];
    c.ra  = w[REG_LSB  +: REG_W];
    c.slv = w[SLV_LSB  +: SLV_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] word_from(input logic err, input logic vld,
                                                  input cmd_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DATA_LSB +: DATA_W] = c.dat;
    w[REG_LSB  +: REG_W]  = c.ra;
    w[SLV_LSB  +: SLV_W]  = c.slv;
    w[VALID_BIT]          = vld;
    w[ERR_BIT]            = err;
    return w;
  endfunction
endpackage

// File: rtl/bcr_cmd_store.sv
module bcr_cmd_store
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              byp_done,
  input  logic              byp_nack,
  output cmd_t              cmd,
  output logic              valid,
  output logic              err
);
  logic load_ok, launch, err_clr, err_set;

  assign load_ok = wr_en & ~valid;
  assign launch  = load_ok & wr_word[VALID_BIT];
  assign err_clr = wr_en & wr_word[ERR_BIT];
  assign err_set = byp_done & byp_nack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd   <= '0;
      valid <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (load_ok) cmd <= cmd_from_word(wr_word);
      if (launch) valid <= 1'b1;
      else if (byp_done) valid <= 1'b0;
      if (err_set) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end
endmodule

// File: rtl/bcr_arb.sv
module bcr_arb
  import bcr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   byp_pend,
  input  cmd_t   byp_cmd,
  input  logic   st_req,
  input  cmd_t   st_cmd,
  input  logic   eng_done,
  output owner_e owner,
  output cmd_t   eng_cmd
);
  logic idle, take_byp, take_st;

  assign idle     = (owner == OWN_IDLE);
  assign take_byp = idle & byp_pend;
  assign take_st  = idle & ~byp_pend & st_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner   <= OWN_IDLE;
      eng_cmd <= '0;
    end else if (take_byp) begin
      owner   <= OWN_BYP;
      eng_cmd <= byp_cmd;
    end else if (take_st) begin
      owner   <= OWN_ST;
      eng_cmd <= st_cmd;
    end else if (!idle && eng_done) begin
      owner   <= OWN_IDLE;
    end
  end
endmodule

// File: rtl/bypass_cmd_reg.sv
module bypass_cmd_reg
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              st_req,
  input  logic [SLV_W-1:0]  st_slave,
  input  logic [REG_W-1:0]  st_reg,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_done,
  output logic              eng_req,
  output logic [SLV_W-1:0]  eng_slave,
  output logic [REG_W-1:0]  eng_reg,
  output logic [DATA_W-1:0] eng_data,
  input  logic              eng_done,
  input  logic              eng_nack
);
  cmd_t   cmd_q, st_cmd, eng_cmd;
  owner_e owner;
  logic   valid_q, err_q;
  logic   byp_active, byp_done;

  assign st_cmd     = '{slv: st_slave, ra: st_reg, dat: st_data};
  assign byp_active = (owner == OWN_BYP);
  assign byp_done   = eng_done & byp_active;

  bcr_cmd_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr),
    .wr_word  (host_wdata),
    .byp_done (byp_done),
    .byp_nack (eng_nack),
    .cmd      (cmd_q),
    .valid    (valid_q),
    .err      (err_q)
  );

  bcr_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .byp_pend (valid_q),
    .byp_cmd  (cmd_q),
    .st_req   (st_req),
    .st_cmd   (st_cmd),
    .eng_done (eng_done),
    .owner    (owner),
    .eng_cmd  (eng_cmd)
  );

  assign host_rdata = word_from(err_q, valid_q, cmd_q);
  assign eng_req    = (owner != OWN_IDLE);
  assign eng_slave  = eng_cmd.slv;
  assign eng_reg    = eng_cmd.ra;
  assign eng_data   = eng_cmd.dat;
  assign st_done    = eng_done & (owner == OWN_ST);
endmodule

// File: rtl/bypass_cmd_reg_chk.sv
module bypass_cmd_reg_chk
  import bcr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] host_rdata,
  input logic              eng_req,
  input logic              eng_done,
  input logic              eng_nack,
  input logic [SLV_W-1:0]  eng_slave,
  input logic [REG_W-1:0]  eng_reg,
  input logic [DATA_W-1:0] eng_data,
  input logic              st_done,
  input logic              byp_active,
  input logic              byp_done
);
  p_clear_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byp_done |=> !host_rdata[VALID_BIT]);

  p_fields_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[VALID_BIT] |=> $stable(host_rdata[SLV_LSB+SLV_W-1:0]));

  p_bypass_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_req && host_rdata[VALID_BIT]) |=> byp_active);

  p_st_done_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> (eng_done && !byp_active));

  p_nack_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_done && eng_nack) |=> host_rdata[ERR_BIT]);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_slave)
                                && $stable(eng_reg) && $stable(eng_data)));
endmodule

bind bypass_cmd_reg bypass_cmd_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_rdata (host_rdata),
  .eng_req    (eng_req),
  .eng_done   (eng_done),
  .eng_nack   (eng_nack),
  .eng_slave  (eng_slave),
  .eng_reg    (eng_reg),
  .eng_data   (eng_data),
  .st_done    (st_done),
  .byp_active (byp_active),
  .byp_done   (byp_done)
);

// File: tb/bypass_cmd_reg_tb_top.sv
module bypass_cmd_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        st_req = 1'b0;
  logic [6:0]  st_slave = '0;
  logic [7:0]  st_reg = '0;
  logic [7:0]  st_data = '0;
  logic        st_done, eng_req;
  logic [6:0]  eng_slave;
  logic [7:0]  eng_reg, eng_data;
  logic        eng_done = 1'b0;
  logic        eng_nack = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  bypass_cmd_reg dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .st_req(st_req), .st_slave(st_slave),
    .st_reg(st_reg), .st_data(st_data), .st_done(st_done), .eng_req(eng_req),
    .eng_slave(eng_slave), .eng_reg(eng_reg), .eng_data(eng_data),
    .eng_done(eng_done), .eng_nack(eng_nack)
  );

  function automatic logic [31:0] mk(input logic e, input logic v, input logic [6:0] s,
                                     input logic [7:0] r, input logic [7:0] d);
    return {e, 6'd0, v, 1'b0, s, r, d};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] w);
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic pulse_done(input logic nack, input logic exp_st);
    @(negedge clk); eng_done = 1'b1; eng_nack = nack;
    #1 chk(st_done == exp_st, "R7 st_done in done cycle", {31'd0, st_done}, {31'd0, exp_st});
    @(negedge clk); eng_done = 1'b0; eng_nack = 1'b0;
  endtask

  task automatic t_reset();
    chk(host_rdata == 32'h0, "R1 word after reset", host_rdata, 32'h0);
    chk(eng_req == 1'b0, "R1 eng_req after reset", {31'd0, eng_req}, 32'h0);
  endtask

  task automatic t_load();
    host_write(32'h7EFF_FFFF);
    chk(host_rdata == 32'h007F_FFFF, "R2 unused bits read zero", host_rdata, 32'h007F_FFFF);
    host_write(mk(1'b0, 1'b0, 7'h2A, 8'h3C, 8'hA5));
    chk(host_rdata == mk(1'b0, 1'b0, 7'h2A, 8'h3C, 8'hA5), "R2 fields loaded",
        host_rdata, mk(1'b0, 1'b0, 7'h2A, 8'h3C, 8'hA5));
    repeat (3) @(negedge clk);
    chk(eng_req == 1'b0, "R2 no transfer without flag", {31'd0, eng_req}, 32'h0);
  endtask

  task automatic t_launch();
    logic [31:0] w;
    w = mk(1'b0, 1'b1, 7'h12, 8'h34, 8'h56);
    host_write(w);
    chk(host_rdata == w, "R3 flag set after write", host_rdata, w);
    @(negedge clk);
    chk(eng_req && eng_slave == 7'h12 && eng_reg == 8'h34 && eng_data == 8'h56,
        "R3 request with fields", {eng_req, 8'd0, eng_slave, eng_reg, eng_data},
        {1'b1, 8'd0, 7'h12, 8'h34, 8'h56});
    repeat (2) @(negedge clk);
    chk(host_rdata[24] && eng_req, "R4 flag held while pending", host_rdata, w);
    host_write(mk(1'b0, 1'b1, 7'h01, 8'h02, 8'h03));
    chk(host_rdata == w, "R5 write ignored while busy", host_rdata, w);
    chk(eng_slave == 7'h12 && eng_data == 8'h56, "R10 engine fields held",
        {17'd0, eng_slave, eng_data}, {17'd0, 7'h12, 8'h56});
    pulse_done(1'b0, 1'b0);
    chk(host_rdata == mk(1'b0, 1'b0, 7'h12, 8'h34, 8'h56), "R4 flag cleared on done",
        host_rdata, mk(1'b0, 1'b0, 7'h12, 8'h34, 8'h56));
    chk(eng_req == 1'b0, "R4 engine released", {31'd0, eng_req}, 32'h0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    st_req = 1'b1; st_slave = 7'h11; st_reg = 8'h22; st_data = 8'h33;
    @(negedge clk);
    chk(eng_req && eng_slave == 7'h11 && eng_reg == 8'h22, "R7 sequencer granted",
        {eng_req, 16'd0, eng_slave, eng_reg}, {1'b1, 16'd0, 7'h11, 8'h22});
    host_write(mk(1'b0, 1'b1, 7'h55, 8'h66, 8'h77));
    st_slave = 7'h44; st_reg = 8'h45; st_data = 8'h46;
    @(negedge clk);
    chk(eng_slave == 7'h11 && eng_data == 8'h33, "R10 fields held across input change",
        {17'd0, eng_slave, eng_data}, {17'd0, 7'h11, 8'h33});
    pulse_done(1'b0, 1'b1);
    @(negedge clk);
    chk(eng_req && eng_slave == 7'h55 && eng_data == 8'h77, "R6 bypass served first",
        {eng_req, 16'd0, eng_slave, eng_data}, {1'b1, 16'd0, 7'h55, 8'h77});
    pulse_done(1'b0, 1'b0);
    @(negedge clk);
    chk(eng_req && eng_slave == 7'h44 && eng_data == 8'h46, "R7 second sequencer request",
        {eng_req, 16'd0, eng_slave, eng_data}, {1'b1, 16'd0, 7'h44, 8'h46});
    @(negedge clk); eng_done = 1'b1;
    #1 chk(st_done == 1'b1, "R7 st_done on sequencer done", {31'd0, st_done}, 32'h1);
    @(negedge clk); eng_done = 1'b0; st_req = 1'b0;
    #1 chk(st_done == 1'b0, "R7 st_done only with done", {31'd0, st_done}, 32'h0);
  endtask

  task automatic t_nack();
    host_write(mk(1'b0, 1'b1, 7'h0F, 8'hF0, 8'h99));
    @(negedge clk);
    pulse_done(1'b1, 1'b0);
    chk(host_rdata == mk(1'b1, 1'b0, 7'h0F, 8'hF0, 8'h99), "R8 error set on nack",
        host_rdata, mk(1'b1, 1'b0, 7'h0F, 8'hF0, 8'h99));
    repeat (2) @(negedge clk);
    chk(host_rdata[31] == 1'b1, "R8 error sticky", host_rdata, 32'h8000_0000);
    host_write(mk(1'b0, 1'b0, 7'h01, 8'h01, 8'h01));
    chk(host_rdata == mk(1'b1, 1'b0, 7'h01, 8'h01, 8'h01), "R9 zero leaves error",
        host_rdata, mk(1'b1, 1'b0, 7'h01, 8'h01, 8'h01));
    host_write(mk(1'b1, 1'b0, 7'h01, 8'h01, 8'h01));
    chk(host_rdata == mk(1'b0, 1'b0, 7'h01, 8'h01, 8'h01), "R9 one clears error",
        host_rdata, mk(1'b0, 1'b0, 7'h01, 8'h01, 8'h01));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_launch();
    t_priority();
    t_nack();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule